// File: doc/BRIEF.md
# Dual Synthesizer Power Control Arbiter

This block decides, once per system clock, whether each of two synthesizer channels (index 0 for the RF channel, index 1 for the IF channel) is running. It also decides whether the shared reference oscillator buffer is running. Each channel has a hardware enable pin and a power-down bit held in a control register. The pin wins over the bit, except that when every enable pin is high, the register bit alone sets the state. A separate doubler-enable bit is never overridden by the pins, and it keeps the reference buffer running even when both channels are down.

For each channel the block drives four controls: a counter enable shared by the channel's N and R counters, a counter reset that is also shared by both, a charge-pump/phase-comparator tri-state control, and a powered-down status that the lock detector uses to force its output low. When a channel wakes, it passes through one wake cycle. In that cycle the counters are enabled but still held in reset. The reset on N and R is then released in the same cycle, so the two counters restart aligned. The serial register interface is outside this block and is never gated by it.

Top module: `pwr_arbiter`

## Requirements
- R1: An enable pin that is low (0) puts its channel into the powered-down state one clock later, whatever the channel's register bit holds.
- R2: When all enable pins are high, a register power-down bit of 1 puts its channel down and 0 brings it up. When the channel's own pin is high and another pin is low, the channel is brought up whatever its bit holds.
- R3: In the powered-down state a channel drives counter enable 0, counter reset 1, tri-state 1 and down status 1.
- R4: A channel whose request changes from down to up spends exactly one wake cycle with counter enable 1, counter reset 1, tri-state 1 and down status 1. On the next clock it reaches the running state: counter reset 0, tri-state 0 and down status 0, with counter enable still 1.
- R5: A down request seen while a channel is waking or running moves it to the powered-down state on the next clock.
- R6: The reference enable goes to 0 one clock after a cycle in which both channels request power-down and the doubler-enable bit is 0. After any other cycle it is 1.
- R7: A doubler-enable bit of 1 keeps the reference enable at 1 on the next clock, even with both pins low.
- R8: After synchronous reset, both channels are in the powered-down state and the reference enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | N_CH | Hardware enable per channel, 1 = enabled |
| pd_bit | input | N_CH | Register power-down bit per channel, 1 = down |
| dbl_en | input | 1 | Doubler-enable register bit |
| cnt_en | output | N_CH | Enable for the channel's N and R counters |
| cnt_rst | output | N_CH | Reset for the channel's N and R counters |
| cp_hiz | output | N_CH | Charge pump and phase comparator tri-state |
| ch_down | output | N_CH | Channel not running; forces lock detect low |
| ref_en | output | 1 | Shared reference buffer enable |

## Verification
The assertions assume that the pins and register bits are synchronous to the system clock and stable around each rising edge. The bench meets this by changing every input one time unit after a falling edge. The pin-based and doubler-based properties also assume that no reset is asserted in the following cycle. The bench asserts reset only in its first cycles, so inputs driven afterwards always satisfy this.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        CH_DOWN = 2'd0,
        CH_WAKE = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic cnt_en;
        logic cnt_rst;
        logic cp_hiz;
        logic down;
    } ch_ctrl_t;

    // Output controls implied by a channel state.
    function automatic ch_ctrl_t ctrl_of(ch_state_e st);
        ch_ctrl_t c;
        c.cnt_en  = (st != CH_DOWN);
        c.cnt_rst = (st != CH_RUN);
        c.cp_hiz  = (st != CH_RUN);
        c.down    = (st != CH_RUN);
        return c;
    endfunction

    // Next state from the current state and the down request.
    function automatic ch_state_e next_state(ch_state_e st, logic dn);
        ch_state_e n;
        n = st;
        if (dn) begin
            n = CH_DOWN;
        end else begin
            unique case (st)
                CH_DOWN: n = CH_WAKE;
                CH_WAKE: n = CH_RUN;
                default: n = CH_RUN;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode #(
    parameter int N_CH = 2
) (
    input  logic [N_CH-1:0] en_pin,
    input  logic [N_CH-1:0] pd_bit,
    output logic [N_CH-1:0] down_req
);
    logic all_pins_high;

    always_comb begin
        all_pins_high = &en_pin;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_req
        always_comb begin
            if (!en_pin[i]) begin
                down_req[i] = 1'b1;
            end else if (all_pins_high) begin
                down_req[i] = pd_bit[i];
            end else begin
                down_req[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwr_chan_fsm.sv
module pwr_chan_fsm
    import pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     down_req,
    output ch_ctrl_t ctrl
);
    ch_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CH_DOWN;
        end else begin
            st_q <= next_state(st_q, down_req);
        end
    end

    always_comb begin
        ctrl = ctrl_of(st_q);
    end
endmodule

// File: rtl/pwr_ref_ctrl.sv
module pwr_ref_ctrl #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] down_req,
    input  logic            dbl_en,
    output logic            ref_en
);
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= dbl_en | ~(&down_req);
        end
    end

    assign ref_en = ref_q;
endmodule

// File: rtl/pwr_arbiter.sv
module pwr_arbiter
    import pwr_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] en_pin,
    input  logic [N_CH-1:0] pd_bit,
    input  logic            dbl_en,
    output logic [N_CH-1:0] cnt_en,
    output logic [N_CH-1:0] cnt_rst,
    output logic [N_CH-1:0] cp_hiz,
    output logic [N_CH-1:0] ch_down,
    output logic            ref_en
);
    logic [N_CH-1:0] down_req;

    pwr_req_decode #(.N_CH(N_CH)) u_dec (
        .en_pin   (en_pin),
        .pd_bit   (pd_bit),
        .down_req (down_req)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        ch_ctrl_t ctrl;

        pwr_chan_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .down_req (down_req[i]),
            .ctrl     (ctrl)
        );

        assign cnt_en[i]  = ctrl.cnt_en;
        assign cnt_rst[i] = ctrl.cnt_rst;
        assign cp_hiz[i]  = ctrl.cp_hiz;
        assign ch_down[i] = ctrl.down;
    end

    pwr_ref_ctrl #(.N_CH(N_CH)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .down_req (down_req),
        .dbl_en   (dbl_en),
        .ref_en   (ref_en)
    );
endmodule

// File: rtl/pwr_arbiter_chk.sv
module pwr_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] en_pin,
    input logic       dbl_en,
    input logic [1:0] cnt_en,
    input logic [1:0] cnt_rst,
    input logic [1:0] cp_hiz,
    input logic [1:0] ch_down,
    input logic       ref_en
);
    // R1
    rf_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en_pin[0] |=> ch_down[0]);

    // R1
    if_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en_pin[1] |=> ch_down[1]);

    // R3
    rf_down_state_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en[0] |-> (cnt_rst[0] && cp_hiz[0] && ch_down[0]));

    // R4
    rf_wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_en[0]) |-> (cnt_rst[0] && cp_hiz[0]));

    // R4
    if_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cnt_rst[1]) |-> $past(cnt_en[1]));

    // R5
    rf_fast_down_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en[0] && !en_pin[0]) |=> !cnt_en[0]);

    // R6
    ref_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en_pin == 2'b00 && !dbl_en) |=> !ref_en);

    // R7
    ref_keep_chk: assert property (@(posedge clk) disable iff (rst)
        dbl_en |=> ref_en);
endmodule

bind pwr_arbiter pwr_arbiter_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_pin  (en_pin),
    .dbl_en  (dbl_en),
    .cnt_en  (cnt_en),
    .cnt_rst (cnt_rst),
    .cp_hiz  (cp_hiz),
    .ch_down (ch_down),
    .ref_en  (ref_en)
);

// File: tb/pwr_arbiter_tb.sv
module pwr_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] en_pin = 2'b00;
    logic [1:0] pd_bit = 2'b00;
    logic       dbl_en = 1'b0;
    logic [1:0] cnt_en, cnt_rst, cp_hiz, ch_down;
    logic       ref_en;

    int total = 0;
    int bad = 0;
    // model: phase 0 = down, 1 = wake, 2 = running
    int ph [2] = '{0, 0};
    int m_ref = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_arbiter u_dut (
        .clk(clk), .rst(rst), .en_pin(en_pin), .pd_bit(pd_bit),
        .dbl_en(dbl_en), .cnt_en(cnt_en), .cnt_rst(cnt_rst),
        .cp_hiz(cp_hiz), .ch_down(ch_down), .ref_en(ref_en)
    );

    function automatic bit wants_down(int i);
        if (en_pin[i] == 1'b0) return 1;
        if (en_pin == 2'b11) return pd_bit[i];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ph[0] <= 0; ph[1] <= 0; m_ref <= 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (wants_down(i)) ph[i] <= 0;
                else if (ph[i] < 2) ph[i] <= ph[i] + 1;
            end
            m_ref <= (dbl_en || !(wants_down(0) && wants_down(1))) ? 1 : 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // R3 R4 R6: compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                chk(ph[i] == 0 ? "R3 cnt_en" : "R4 cnt_en", cnt_en[i], ph[i] != 0);
                chk(ph[i] == 2 ? "R4 cnt_rst" : "R3 cnt_rst", cnt_rst[i], ph[i] != 2);
                chk("R3/R4 cp_hiz", cp_hiz[i], ph[i] != 2);
                chk("R3/R4 ch_down", ch_down[i], ph[i] != 2);
            end
            chk("R6 ref_en", ref_en, m_ref);
        end
    end

    task automatic step(logic [1:0] p, logic [1:0] b, logic d);
        @(negedge clk); #1;
        en_pin = p; pd_bit = b; dbl_en = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 ch_down", ch_down, 3);
        chk("R8 ref_en", ref_en, 0);
        #1 rst = 1'b0;

        // R2: all pins high, bits pick the state
        step(2'b11, 2'b10, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 ch0 up", ch_down[0], 0);
        chk("R2 ch1 down", ch_down[1], 1);
        // R2: own pin high, other low -> up despite bit
        step(2'b01, 2'b11, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 pin beats bit", ch_down[0], 0);
        // R1: pin low forces down one clock later
        step(2'b10, 2'b00, 1'b0);
        @(negedge clk);
        chk("R1 ch0 down", ch_down[0], 1);
        // R5: down from wake
        step(2'b11, 2'b00, 1'b0);
        @(negedge clk);
        chk("R4 wake", cnt_en[0] && cnt_rst[0], 1);
        step(2'b11, 2'b01, 1'b0);
        @(negedge clk);
        chk("R5 from wake", cnt_en[0], 0);
        // R6: both off, no doubler
        step(2'b00, 2'b00, 1'b0);
        @(negedge clk);
        chk("R6 ref off", ref_en, 0);
        // R7: doubler keeps reference on
        step(2'b00, 2'b00, 1'b1);
        @(negedge clk);
        chk("R7 ref kept", ref_en, 1);
        // sweep all input patterns
        for (int k = 0; k < 64; k++) begin
            step(k[1:0], k[3:2], k[4]);
            if (k[5]) step(2'b11, 2'b00, 1'b0);
        end
        repeat (4) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule